// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Inserter

This block sits in the transmit data path of a T1 framer. It takes the serial NRZ payload and a serial stream of per-channel signaling bits. During signaling frames, it replaces the least significant bit of each 8-bit DS0 channel with the signaling bit presented in the same cycle. An upstream frame timing generator supplies the slot position: an F-bit strobe, the channel number, the bit number inside the channel, the frame number and the framing mode, which is superframe (12 frames) or extended superframe (24 frames). The merged stream leaves the block after a fixed latency of ten bit-clock periods.

A small state machine classifies each frame when its F-bit arrives. After reset it waits in `FS_SYNC_WAIT`. On every F-bit strobe it moves to `FS_SIGNAL` if the frame number being announced is a signaling frame for the current mode, and to `FS_PLAIN` otherwise. The transitions are `SYNC_WAIT->PLAIN`, `SYNC_WAIT->SIGNAL`, `PLAIN->SIGNAL`, `SIGNAL->PLAIN`, and the self-loops `PLAIN->PLAIN` and `SIGNAL->SIGNAL`. Without a strobe it holds its state. A combinational slot merger uses that class, the enables and a per-channel transparency mask to pick either payload or signaling. A ten-stage shift register then delays the result. In superframe mode the two signaling frames carry bits A and B. In extended superframe mode the four signaling frames carry A, B, C and D. The caller supplies the matching bit on the signaling input.

Top module: `rbs_inserter`

## Requirements
- R1: When insertion is active, the frame is a signaling frame and the channel is not transparent, the output bit for slot `bit_idx == 7` (the eighth, least significant bit) of a channel equals the `sig_in` value sampled with that slot.
- R2: Signaling frames are frame numbers 6 and 12 with `esf_mode = 0`, and 6, 12, 18 and 24 with `esf_mode = 1` (frames numbered from 1). In every other frame the eighth bit passes the payload unchanged.
- R3: Bit c of `transp_mask` (c = channel number 0..23) set to 1 makes channel c pass its payload unchanged, even in signaling frames. Channel numbers of 24 or above are treated as transparent.
- R4: Insertion is active when `ins_enable = 1` or `hw_mode = 1`. With both at 0, every bit passes unchanged.
- R5: A bit sampled at rising edge n appears on `line_out` after rising edge n+9, which is ten bit periods after the period in which it was presented.
- R6: A slot with `fbit_strobe = 1` always passes `ser_in` unchanged, whatever `chan_idx` and `bit_idx` hold.
- R7: While `rst_n` is low, and for the nine periods after its release, `line_out` is 0. Until the first F-bit strobe the frame class is plain.
- R8: Bits 0 to 6 of every channel are never altered.
- R9: The frame class is decided only from `frame_num` and `esf_mode` sampled with the F-bit strobe. Changes to these inputs during the rest of the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial NRZ payload |
| sig_in | input | 1 | Serial signaling bit aligned with the payload slot |
| fbit_strobe | input | 1 | High in the F-bit slot of a frame |
| chan_idx | input | 5 | DS0 channel number of the current slot, 0..23 |
| bit_idx | input | 3 | Bit number inside the channel, 7 = least significant |
| frame_num | input | 5 | Frame number in the multiframe, from 1, read at the F-bit |
| esf_mode | input | 1 | 1 = 24-frame extended superframe, 0 = 12-frame superframe |
| ins_enable | input | 1 | Signaling insertion enable |
| hw_mode | input | 1 | Forces insertion on regardless of `ins_enable` |
| transp_mask | input | 24 | Per-channel transparency, bit c for channel c |
| line_out | output | 1 | Merged serial stream, ten periods behind the inputs |

## Verification
The hardest situation to reach from the ports is a mismatch between the frame number held on the inputs during a frame and the class latched at its F-bit. A timing generator that behaves correctly never produces one. The bench drives whole multiframes in both modes, with several enable and mask settings, and checks every output bit against an arithmetic model. In one extended-superframe pass it scrambles `frame_num` on every payload slot after the F-bit. That pass exposes any design that reads the frame number at a time other than the strobe.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    localparam int NUM_CH      = 24;
    localparam int BITS_PER_CH = 8;
    localparam int LATENCY     = 10;
    localparam int CH_W        = $clog2(NUM_CH);
    localparam int BIT_W       = $clog2(BITS_PER_CH);
    localparam int FRAME_W     = 5;
    localparam int SF_FRAMES   = 12;
    localparam int ESF_FRAMES  = 24;
    localparam int SIG_PERIOD  = 6;

    typedef enum logic [1:0] {
        FS_SYNC_WAIT = 2'd0,
        FS_PLAIN     = 2'd1,
        FS_SIGNAL    = 2'd2
    } frm_state_e;

    // Signaling frames are every SIG_PERIOD-th frame inside the multiframe.
    function automatic logic is_sig_frame(input logic [FRAME_W-1:0] fnum,
                                          input logic esf);
        int lim;
        lim = esf ? ESF_FRAMES : SF_FRAMES;
        return (int'(fnum) != 0) && (int'(fnum) <= lim) &&
               ((int'(fnum) % SIG_PERIOD) == 0);
    endfunction

endpackage

// File: rtl/rbs_frame_tracker.sv
module rbs_frame_tracker
    import rbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fbit_strobe,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic               esf_mode,
    output logic               sig_frame
);

    frm_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_SYNC_WAIT;
        else        state_q <= state_d;
    end

    // next-state decision: only an F-bit strobe moves the machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_SYNC_WAIT,
            FS_PLAIN,
            FS_SIGNAL: begin
                if (fbit_strobe)
                    state_d = is_sig_frame(frame_num, esf_mode) ? FS_SIGNAL : FS_PLAIN;
            end
            default: state_d = FS_SYNC_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FS_SIGNAL:    sig_frame = 1'b1;
            FS_PLAIN:     sig_frame = 1'b0;
            FS_SYNC_WAIT: sig_frame = 1'b0;
            default:      sig_frame = 1'b0;
        endcase
    end

    AST_SF_FRAME12_SIGNALS: assert property (@(posedge clk) disable iff (!rst_n)
        (fbit_strobe && !esf_mode && frame_num == 5'd12) |=> sig_frame) else $error("AST_SF_FRAME12_SIGNALS"); // R2
    AST_ESF_FRAME18_SIGNALS: assert property (@(posedge clk) disable iff (!rst_n)
        (fbit_strobe && esf_mode && frame_num == 5'd18) |=> sig_frame) else $error("AST_ESF_FRAME18_SIGNALS"); // R2
    AST_FRAME1_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (fbit_strobe && frame_num == 5'd1) |=> !sig_frame) else $error("AST_FRAME1_PLAIN"); // R2
    AST_CLASS_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !fbit_strobe |=> $stable(sig_frame)) else $error("AST_CLASS_HELD_MIDFRAME"); // R9

endmodule

// File: rtl/rbs_slot_merge.sv
module rbs_slot_merge
    import rbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              sig_in,
    input  logic              fbit_strobe,
    input  logic [CH_W-1:0]   chan_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              sig_frame,
    input  logic              ins_enable,
    input  logic              hw_mode,
    input  logic [NUM_CH-1:0] transp_mask,
    output logic              merged
);

    localparam int                MASK_SPAN = 2 ** CH_W;
    localparam logic [BIT_W-1:0]  LSB_SLOT  = BIT_W'(BITS_PER_CH - 1);

    logic [MASK_SPAN-1:0] mask_pad;
    logic                 chan_transp;
    logic                 active;
    logic                 rob;

    // out-of-range channel numbers read as transparent
    always_comb begin
        mask_pad              = '1;
        mask_pad[NUM_CH-1:0]  = transp_mask;
        chan_transp           = mask_pad[chan_idx];
    end

    always_comb begin
        active = ins_enable | hw_mode;
        rob    = active && sig_frame && !fbit_strobe &&
                 (bit_idx == LSB_SLOT) && !chan_transp;
        merged = rob ? sig_in : ser_in;
    end

    AST_FBIT_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_strobe |-> (merged == ser_in)) else $error("AST_FBIT_UNTOUCHED"); // R6
    AST_UPPER_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx != LSB_SLOT) |-> (merged == ser_in)) else $error("AST_UPPER_BITS_PASS"); // R8
    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_enable && !hw_mode) |-> (merged == ser_in)) else $error("AST_DISABLED_PASS"); // R4
    AST_PLAIN_FRAME_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_frame |-> (merged == ser_in)) else $error("AST_PLAIN_FRAME_PASS"); // R2

endmodule

// File: rtl/rbs_delay_line.sv
module rbs_delay_line #(
    parameter int DEPTH = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[DEPTH-2:0], din};
    end

    assign dout = stage[DEPTH-1];

    AST_STAGE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage[0] == $past(din))) else $error("AST_STAGE_ENTRY"); // R5

    for (genvar gi = 1; gi < DEPTH; gi++) begin : g_adv
        AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (stage[gi] == $past(stage[gi-1]))) else $error("AST_STAGE_ADVANCE"); // R5
    end

endmodule

// File: rtl/rbs_inserter.sv
module rbs_inserter
    import rbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              sig_in,
    input  logic              fbit_strobe,
    input  logic [CH_W-1:0]   chan_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic              esf_mode,
    input  logic              ins_enable,
    input  logic              hw_mode,
    input  logic [NUM_CH-1:0] transp_mask,
    output logic              line_out
);

    logic sig_frame;
    logic merged;

    rbs_frame_tracker u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .fbit_strobe (fbit_strobe),
        .frame_num   (frame_num),
        .esf_mode    (esf_mode),
        .sig_frame   (sig_frame)
    );

    rbs_slot_merge u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .sig_in      (sig_in),
        .fbit_strobe (fbit_strobe),
        .chan_idx    (chan_idx),
        .bit_idx     (bit_idx),
        .sig_frame   (sig_frame),
        .ins_enable  (ins_enable),
        .hw_mode     (hw_mode),
        .transp_mask (transp_mask),
        .merged      (merged)
    );

    rbs_delay_line #(.DEPTH(LATENCY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (merged),
        .dout  (line_out)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !line_out) else $error("AST_RESET_QUIET"); // R7

endmodule

// File: tb/rbs_inserter_tb.sv
module rbs_inserter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 10;
    localparam int MEM_N      = 32768;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0, sig_in = 1'b0, fbit_strobe = 1'b0;
    logic [4:0]  chan_idx = '0;
    logic [2:0]  bit_idx = '0;
    logic [4:0]  frame_num = '0;
    logic        esf_mode = 1'b0, ins_enable = 1'b0, hw_mode = 1'b0;
    logic [23:0] transp_mask = '0;
    logic        line_out;

    int errors = 0;
    int checks = 0;
    int drv_idx = 0;
    int n_pos = 0;
    int cyc = 0;
    bit checking = 1'b0;
    bit finished = 1'b0;

    logic exp_mem [0:MEM_N-1];
    byte  tag_mem [0:MEM_N-1];

    // block configuration used by the model
    logic        c_esf, c_en, c_hw, c_scr;
    logic [23:0] c_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbs_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sig_in(sig_in),
        .fbit_strobe(fbit_strobe), .chan_idx(chan_idx), .bit_idx(bit_idx),
        .frame_num(frame_num), .esf_mode(esf_mode), .ins_enable(ins_enable),
        .hw_mode(hw_mode), .transp_mask(transp_mask), .line_out(line_out)
    );

    function automatic string tag_name(input byte t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R5";
        endcase
    endfunction

    function automatic bit model_sig_frame(input int f, input bit esf);
        int lim;
        lim = esf ? 24 : 12;
        return (f >= 1) && (f <= lim) && (f % 6 == 0);
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check_bit(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (R5 path): line_out=%0b expected=%0b at cycle %0d",
                     req, act, exp, n_pos);
        end
    endtask

    // drive one slot and record its expected merged value
    task automatic drive_slot(input bit fb, input int ch, input int bi, input int f);
        logic d, s, e;
        bit   sigf, act, rob;
        byte  t;
        d = 1'($urandom());
        s = 1'($urandom());
        ser_in      = d;
        sig_in      = s;
        fbit_strobe = fb;
        chan_idx    = 5'(ch);
        bit_idx     = 3'(bi);
        esf_mode    = (c_scr && !fb) ? ~c_esf : c_esf;
        frame_num   = (c_scr && !fb) ? (5'(f) ^ 5'h03) : 5'(f);
        ins_enable  = c_en;
        hw_mode     = c_hw;
        transp_mask = c_mask;
        sigf = model_sig_frame(f, c_esf);
        act  = c_en || c_hw;
        rob  = !fb && (bi == 7) && act && sigf && !c_mask[ch];
        e    = rob ? s : d;
        if (drv_idx < LAT - 1)   t = 7;
        else if (fb)             t = 6;
        else if (bi != 7)        t = 8;
        else if (!act)           t = 4;
        else if (c_scr)          t = 9;
        else if (!sigf)          t = 2;
        else if (c_mask[ch])     t = 3;
        else                     t = 1;
        exp_mem[drv_idx] = e;
        tag_mem[drv_idx] = t;
        drv_idx++;
        @(negedge clk);
    endtask

    task automatic run_block(input bit esf, input bit en, input bit hw,
                             input logic [23:0] mask, input bit scr);
        int nfr;
        c_esf = esf; c_en = en; c_hw = hw; c_mask = mask; c_scr = scr;
        nfr = esf ? 24 : 12;
        for (int f = 1; f <= nfr; f++) begin
            drive_slot(1'b1, $urandom_range(0, 23), 7, f);
            for (int ch = 0; ch < 24; ch++)
                for (int bi = 0; bi < 8; bi++)
                    drive_slot(1'b0, ch, bi, f);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) n_pos <= n_pos + 1;
        cyc <= cyc + 1;
    end

    // output checker: after rising edge p, line_out holds the slot sampled at p-9
    always @(negedge clk) begin
        if (checking && n_pos > 0) begin
            if (n_pos - 1 < LAT - 1)
                check_bit(line_out, 1'b0, "R7");
            else
                check_bit(line_out, exp_mem[n_pos - LAT], tag_name(tag_mem[n_pos - LAT]));
        end
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        c_esf = 0; c_en = 0; c_hw = 0; c_scr = 0; c_mask = '0;
        repeat (4) @(negedge clk);
        checks++;
        if (line_out !== 1'b0) begin
            errors++;
            $display("FAIL R7: line_out during reset=%0b expected=0", line_out);
        end
        rst_n    = 1'b1;
        checking = 1'b1;
        // R1 R2: superframe, all channels robbed
        run_block(1'b0, 1'b1, 1'b0, 24'h000000, 1'b0);
        // R3: superframe with a sparse transparency mask
        run_block(1'b0, 1'b1, 1'b0, 24'hA53C96, 1'b0);
        // R2: extended superframe, frames 18 and 24 included
        run_block(1'b1, 1'b1, 1'b0, 24'h000000, 1'b0);
        // R4: hardware mode forces insertion with enable off; edge channels transparent
        run_block(1'b1, 1'b0, 1'b1, 24'h800001, 1'b0);
        // R4: both enables off
        run_block(1'b0, 1'b0, 1'b0, 24'h000000, 1'b0);
        // R9: frame number and mode scrambled after every F-bit
        run_block(1'b1, 1'b1, 1'b0, 24'h0F0F0F, 1'b1);
        // flush the pipeline with plain slots (R5)
        c_en = 1'b0; c_hw = 1'b0; c_scr = 1'b0;
        for (int k = 0; k < LAT + 2; k++) drive_slot(1'b0, 0, 0, 1);
        checking = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

endmodule